// File: doc/BRIEF.md
# Blanking-Gated Counter Run Controller

This block sits next to one or more timer channels and decides, cycle by cycle, whether each channel's counter should advance, hold its value, or be cleared to zero. It watches a single raw blanking level. A falling edge of that level is treated as the gate start and a rising edge as the gate end. Both edges are found by comparing two registered samples of the input.

Each channel has a gate-enable level, a 2-bit gate mode and a mode-write strobe. These come from that channel's configuration register, which lives elsewhere. The channel produces a count-enable level and a one-cycle synchronous clear pulse for its counter. When gating is off, the counter simply runs. When gating is on, one of four gate behaviours applies:

- hold inside the gate and restart at its end;
- run through the gate and restart at every end;
- count only inside the gate;
- wait for the first gate end, then run freely for good.

Top module: `gate_run_ctrl`

## Requirements
- R1: While a channel's gate enable is 0, its cnt_en is 1 and its cnt_clr is 0, whatever the blanking input does.
- R2: A gate start event is a 1-to-0 change of blank_in and a gate end event is a 0-to-1 change. The event is active for exactly one cycle: the cycle after the first rising clock edge that samples the new level. cnt_clr, when caused, is high in that same cycle, and any change of cnt_en caused by the event appears one cycle later.
- R3: A cycle with mode_wr high and gate enable 1 puts the channel in the stopped state. cnt_en is 0 from the next cycle until an event of the selected mode restarts it.
- R4: Mode code 0: a gate start stops counting (cnt_en 0 from the next cycle). A gate end pulses cnt_clr and restarts counting.
- R5: Mode code 1: a gate start has no effect on cnt_en or cnt_clr. Every gate end pulses cnt_clr and leaves the channel running.
- R6: Mode code 2: a gate start pulses cnt_clr and starts counting. A gate end stops counting without a clear.
- R7: Mode code 3: after a mode write the channel stays stopped until the first gate end. That gate end pulses cnt_clr and starts counting. Later gate starts and gate ends have no effect until the next mode write.
- R8: A gate event that falls in a cycle with mode_wr high on a channel produces no cnt_clr on that channel, and the channel is left stopped as in R3.
- R9: After reset, with gate enable 0 on every channel, every cnt_en is 1 and every cnt_clr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_in | input | 1 | Raw blanking level shared by all channels |
| gate_en | input | NUM_CH | Per-channel gate enable level |
| gate_mode | input | 2*NUM_CH | Per-channel gate mode code, channel c in bits [2c+1:2c] |
| mode_wr | input | NUM_CH | Per-channel one-cycle strobe marking a write of that channel's mode |
| cnt_en | output | NUM_CH | Per-channel count-enable level |
| cnt_clr | output | NUM_CH | Per-channel one-cycle clear pulse |

## Verification
The assertions take for granted that gate_en and gate_mode for a channel change only in a cycle where that channel's mode_wr is high. They also take for granted that blank_in is already synchronous to clk. The stimulus changes configuration only through a one-cycle write that carries the new enable and mode together. It drives blank_in only between clock edges, with high and low runs of varied lengths, some as short as one cycle. It also places one write exactly on a gate end to exercise the priority rule.

// File: rtl/gate_run_pkg.sv
package gate_run_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    GM_HOLD_IN   = 2'd0,
    GM_CLEAR_END = 2'd1,
    GM_WINDOW    = 2'd2,
    GM_ARM_END   = 2'd3
  } gate_mode_e;

  typedef struct packed {
    logic run_nxt;
    logic clr;
  } gate_step_t;

  // Next run state and clear request for one gate event.
  function automatic gate_step_t gate_step(gate_mode_e mode, logic run,
                                           logic g_start, logic g_end);
    gate_step_t r;
    r.run_nxt = run;
    r.clr     = 1'b0;
    unique case (mode)
      GM_HOLD_IN: begin
        if (g_start) r.run_nxt = 1'b0;
        if (g_end) begin
          r.run_nxt = 1'b1;
          r.clr     = 1'b1;
        end
      end
      GM_CLEAR_END: begin
        if (g_end) begin
          r.run_nxt = 1'b1;
          r.clr     = 1'b1;
        end
      end
      GM_WINDOW: begin
        if (g_start) begin
          r.run_nxt = 1'b1;
          r.clr     = 1'b1;
        end
        if (g_end) r.run_nxt = 1'b0;
      end
      GM_ARM_END: begin
        if (g_end && !run) begin
          r.run_nxt = 1'b1;
          r.clr     = 1'b1;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gate_edge_detect.sv
module gate_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic blank_in,
  output logic gate_start,
  output logic gate_end
);

  logic samp_now;
  logic samp_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_now <= 1'b0;
      samp_old <= 1'b0;
    end else begin
      samp_now <= blank_in;
      samp_old <= samp_now;
    end
  end

  assign gate_start = samp_old & ~samp_now;
  assign gate_end   = ~samp_old & samp_now;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_start && gate_end)); // R2
  AST_START_IS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    gate_start |-> ($past(blank_in, 2) && !$past(blank_in))); // R2
  AST_END_IS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |-> (!$past(blank_in, 2) && $past(blank_in))); // R2

endmodule

// File: rtl/gate_run_fsm.sv
module gate_run_fsm
  import gate_run_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [MODE_W-1:0] gate_mode,
  input  logic              mode_wr,
  input  logic              gate_start,
  input  logic              gate_end,
  output logic              cnt_en,
  output logic              cnt_clr
);

  logic       run_q;
  gate_mode_e mode_e;
  gate_step_t step;
  logic       evt_live;

  assign mode_e   = gate_mode_e'(gate_mode);
  assign step     = gate_step(mode_e, run_q, gate_start, gate_end);
  assign evt_live = gate_en & ~mode_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (mode_wr)  run_q <= 1'b0;
    else if (gate_en)  run_q <= step.run_nxt;
  end

  assign cnt_en  = ~gate_en | run_q;
  assign cnt_clr = evt_live & step.clr;

  AST_CLR_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> gate_en); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> !cnt_clr); // R8
  AST_WRITE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !run_q); // R3
  AST_HOLD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !mode_wr && mode_e == GM_HOLD_IN && gate_start) |=> !run_q); // R4
  AST_CLR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> run_q); // R5
  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !mode_wr && mode_e == GM_WINDOW && gate_end) |=> !run_q); // R6
  AST_FREE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !mode_wr && mode_e == GM_ARM_END && run_q) |=> run_q); // R7

endmodule

// File: rtl/gate_run_ctrl.sv
module gate_run_ctrl
  import gate_run_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     blank_in,
  input  logic [NUM_CH-1:0]        gate_en,
  input  logic [NUM_CH*MODE_W-1:0] gate_mode,
  input  logic [NUM_CH-1:0]        mode_wr,
  output logic [NUM_CH-1:0]        cnt_en,
  output logic [NUM_CH-1:0]        cnt_clr
);

  logic gate_start;
  logic gate_end;

  gate_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank_in   (blank_in),
    .gate_start (gate_start),
    .gate_end   (gate_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gate_run_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_en    (gate_en[c]),
      .gate_mode  (gate_mode[c*MODE_W +: MODE_W]),
      .mode_wr    (mode_wr[c]),
      .gate_start (gate_start),
      .gate_end   (gate_end),
      .cnt_en     (cnt_en[c]),
      .cnt_clr    (cnt_clr[c])
    );
  end

endmodule

// File: tb/gate_run_ctrl_test.sv
module gate_run_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank = 1'b0;
  logic [NCH-1:0] ge = '0;
  logic [2*NCH-1:0] gm = '0;
  logic [NCH-1:0] wr = '0;
  logic [NCH-1:0] en_o;
  logic [NCH-1:0] clr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int h_new = 0;
  int h_old = 0;
  int run_m [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_run_ctrl #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .blank_in(blank),
    .gate_en(ge), .gate_mode(gm), .mode_wr(wr),
    .cnt_en(en_o), .cnt_clr(clr_o)
  );

  task automatic check(string tag, int ch, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s ch%0d %s actual=%0d expected=%0d", tag, ch, what, act, exp);
    end
  endtask

  // Compare outputs for the current cycle, then advance the model as the
  // coming rising edge will, then move to the next falling edge.
  task automatic cyc(string tag);
    int fall;
    int rise;
    #1;
    fall = (h_old == 1 && h_new == 0) ? 1 : 0;
    rise = (h_old == 0 && h_new == 1) ? 1 : 0;
    for (int c = 0; c < NCH; c++) begin
      int m;
      int exp_en;
      int exp_clr;
      int nxt;
      m = int'(gm[2*c +: 2]);
      exp_en = (ge[c] == 1'b0 || run_m[c] == 1) ? 1 : 0;
      exp_clr = 0;
      nxt = run_m[c];
      if (ge[c]) begin
        case (m)
          0: begin if (fall) nxt = 0; if (rise) begin nxt = 1; exp_clr = 1; end end
          1: begin if (rise) begin nxt = 1; exp_clr = 1; end end
          2: begin if (fall) begin nxt = 1; exp_clr = 1; end if (rise) nxt = 0; end
          default: begin if (rise && run_m[c] == 0) begin nxt = 1; exp_clr = 1; end end
        endcase
      end
      if (wr[c]) begin
        exp_clr = 0;
        nxt = 0;
      end
      check(tag, c, "cnt_en", int'(en_o[c]), exp_en);
      check(tag, c, "cnt_clr", int'(clr_o[c]), exp_clr);
      run_m[c] = nxt;
    end
    h_old = h_new;
    h_new = blank ? 1 : 0;
    @(negedge clk);
  endtask

  task automatic write_mode(int ch, bit en, int mode, string tag);
    ge[ch] = en;
    gm[2*ch +: 2] = 2'(mode);
    wr[ch] = 1'b1;
    cyc(tag);
    wr[ch] = 1'b0;
  endtask

  task automatic hold_blank(bit lvl, int n, string tag);
    blank = lvl;
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pattern(string tag);
    hold_blank(1'b0, 3, tag);
    hold_blank(1'b1, 4, tag);
    hold_blank(1'b0, 1, tag);
    hold_blank(1'b1, 1, tag);
    hold_blank(1'b0, 5, tag);
    hold_blank(1'b1, 2, tag);
    hold_blank(1'b0, 3, tag);
    hold_blank(1'b1, 3, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) run_m[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R9 reset");
    cyc("R9 reset");

    pattern("R1 ungated");

    write_mode(0, 1'b1, 0, "R3 write mode0");
    write_mode(1, 1'b1, 1, "R3 write mode1");
    cyc("R3 stopped");
    pattern("R4 R5 modes 0 and 1");

    write_mode(0, 1'b1, 2, "R3 write mode2");
    write_mode(1, 1'b1, 3, "R3 write mode3");
    pattern("R6 R7 modes 2 and 3");
    pattern("R7 sticky free run");

    write_mode(1, 1'b1, 3, "R3 rearm mode3");
    hold_blank(1'b0, 2, "R7 rearmed");
    blank = 1'b1;
    cyc("R2 rise sampled");
    write_mode(0, 1'b1, 1, "R8 write on end");
    hold_blank(1'b1, 2, "R8 after write");
    hold_blank(1'b0, 2, "R5 start ignored");
    hold_blank(1'b1, 3, "R5 end clears");

    write_mode(0, 1'b0, 2, "R1 gate off");
    write_mode(1, 1'b0, 0, "R1 gate off");
    pattern("R1 ungated again");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule